// File: doc/BRIEF.md
# Programmable Line Clamp Pulse Generator

This block generates the once-per-line clamp strobe for a video digitizer. It runs on the sample clock. The strobe can come from one of two sources.

- **Internal source.** The block watches the line sync for the end of its active phase. After the trailing edge it waits a programmed number of clocks (the placement). It then drives the strobe high for a programmed number of clocks (the duration).
- **External source.** The block forwards an external clamp input, after correcting its polarity, to the same output.

The output is a single active-high clamp strobe, `clamp_o`.

Five settings live in a small configuration register: placement, duration, sync polarity, source select and external polarity. All five are captured together on a load strobe. Each comes out of reset at a defined default.

Both asynchronous inputs have the same handling:
- The polarity correction is applied before the synchronizer.
- Each is synchronized through a parameterized flop chain. The default is two stages.

If a new trailing edge arrives while a pulse is pending or active, the timing restarts from that edge.

Top module: `clamp_pulse_gen`

## Requirements
- R1: After reset `clamp_o` is 0 and the configuration holds placement 128, duration 128, sync active high, internal source and external clamp active low.
- R2: All five configuration fields are captured together at a clock edge where `cfg_load_i` is 1. When `cfg_load_i` is 0, changes on the field inputs have no effect on `clamp_o`.
- R3: `sync_high_i` = 1 treats `line_sync_i` = 1 as active. `sync_high_i` = 0 treats `line_sync_i` = 0 as active.
- R4: Let n be the clock edge where the line sync is first sampled inactive after being active. With placement P and duration D > 0, in internal mode `clamp_o` is 1 after edges n+2+P through n+1+P+D, and 0 otherwise. One placement LSB equals one clock.
- R5: In internal mode, a duration of 0 produces no clamp pulse at all. A nonzero duration D holds `clamp_o` high for exactly D clocks.
- R6: A placement of 0 raises `clamp_o` after edge n+2, which is the clock after the trailing edge is detected.
- R7: A trailing edge that arrives during placement counting or during the active pulse restarts the placement count from the new edge, as in R4.
- R8: With `src_ext_i` = 1, `clamp_o` after edge m equals the polarity-corrected external clamp sampled at edge m-1. `ext_low_i` = 1 means the external input is active low.
- R9: In external mode, line sync activity has no effect on `clamp_o`.
- R10: A leading edge of the line sync, or a sync held active for any length, does not start a clamp pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_sync_i | input | 1 | Line sync, asynchronous, polarity set by configuration |
| ext_clamp_i | input | 1 | External clamp, asynchronous, polarity set by configuration |
| cfg_load_i | input | 1 | Captures all configuration fields at the clock edge |
| place_i | input | 8 | Placement in clocks after the sync trailing edge |
| dur_i | input | 8 | Clamp length in clocks |
| sync_high_i | input | 1 | 1: sync active high; 0: sync active low |
| src_ext_i | input | 1 | 0: internal timed clamp; 1: external clamp |
| ext_low_i | input | 1 | 1: external clamp active low; 0: active high |
| clamp_o | output | 1 | Active-high clamp strobe |

## Verification
The restart case is the hardest to reach from the ports. A second trailing edge has to land inside the window opened by the first one. That needs a line period shorter than placement plus duration, and it has to land once during placement and once during the active pulse.

Directed stimulus covers this. It sets placement 10 and duration 20, then sends lines of period 8 and 18. These periods put the second edge in each phase. Random line periods from 2 to 78 clocks against small placements and durations then reach the same window many more times.

Polarity changes are made only while the sync is idle. The pin is flipped on the clock after the load, so the normalized level never glitches.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

  parameter int unsigned CNT_W = 8;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t place;
    cnt_t dur;
    logic sync_high;
    logic src_ext;
    logic ext_low;
  } clamp_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PLACE = 2'd1,
    ST_HOLD  = 2'd2
  } clamp_st_e;

endpackage

// File: rtl/clamp_cfg_reg.sv
module clamp_cfg_reg
  import clamp_pkg::*;
#(
  parameter int unsigned DEF_PLACE     = 128,
  parameter int unsigned DEF_DUR       = 128,
  parameter bit          DEF_SYNC_HIGH = 1'b1,
  parameter bit          DEF_SRC_EXT   = 1'b0,
  parameter bit          DEF_EXT_LOW   = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  clamp_cfg_t cfg_i,
  output clamp_cfg_t cfg_o
);

  localparam clamp_cfg_t CfgRst = '{
    place:     cnt_t'(DEF_PLACE),
    dur:       cnt_t'(DEF_DUR),
    sync_high: DEF_SYNC_HIGH,
    src_ext:   DEF_SRC_EXT,
    ext_low:   DEF_EXT_LOW
  };

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_o <= CfgRst;
    else if (load_i) cfg_o <= cfg_i;
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_o));

endmodule

// File: rtl/clamp_sync.sv
module clamp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/clamp_sync_edge.sv
module clamp_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic act_high_i,
  output logic trail_o
);

  logic norm_in;
  logic lvl;
  logic lvl_q;

  // polarity fixed before the synchronizer so reset level means inactive
  assign norm_in = sync_i ^ ~act_high_i;

  clamp_sync #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (norm_in),
    .q_o    (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl;
  end

  assign trail_o = lvl_q & ~lvl;

  // R10
  no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |=> !trail_o);

endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
  import clamp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trail_i,
  input  cnt_t place_i,
  input  cnt_t dur_i,
  output logic clamp_o
);

  clamp_st_e st_q, st_d;
  cnt_t      cnt_q, cnt_d;
  logic      clamp_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    clamp_d = clamp_o;
    if (trail_i) begin
      if (dur_i == '0) begin
        st_d    = ST_IDLE;
        clamp_d = 1'b0;
      end else if (place_i == '0) begin
        st_d    = ST_HOLD;
        cnt_d   = dur_i - cnt_t'(1);
        clamp_d = 1'b1;
      end else begin
        st_d    = ST_PLACE;
        cnt_d   = place_i - cnt_t'(1);
        clamp_d = 1'b0;
      end
    end else begin
      unique case (st_q)
        ST_PLACE: begin
          if (cnt_q != '0) begin
            cnt_d = cnt_q - cnt_t'(1);
          end else if (dur_i == '0) begin
            st_d = ST_IDLE;
          end else begin
            st_d    = ST_HOLD;
            cnt_d   = dur_i - cnt_t'(1);
            clamp_d = 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt_q != '0) begin
            cnt_d = cnt_q - cnt_t'(1);
          end else begin
            st_d    = ST_IDLE;
            clamp_d = 1'b0;
          end
        end
        default: begin
          st_d    = ST_IDLE;
          clamp_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      clamp_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      clamp_o <= clamp_d;
    end
  end

  // R5
  zero_dur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clamp_o) |-> $past(dur_i) != '0);

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trail_i && place_i != '0) |=> !clamp_o);

  // R4
  place_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PLACE && cnt_q != '0 && !trail_i) |=> !clamp_o);

  // R5
  hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && cnt_q != '0 && !trail_i) |=> clamp_o);

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
  import clamp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned DEF_PLACE     = 128,
  parameter int unsigned DEF_DUR       = 128,
  parameter bit          DEF_SYNC_HIGH = 1'b1,
  parameter bit          DEF_SRC_EXT   = 1'b0,
  parameter bit          DEF_EXT_LOW   = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_sync_i,
  input  logic             ext_clamp_i,
  input  logic             cfg_load_i,
  input  logic [CNT_W-1:0] place_i,
  input  logic [CNT_W-1:0] dur_i,
  input  logic             sync_high_i,
  input  logic             src_ext_i,
  input  logic             ext_low_i,
  output logic             clamp_o
);

  clamp_cfg_t cfg_in, cfg_q;
  logic       trail;
  logic       int_clamp;
  logic       ext_lvl;

  assign cfg_in = '{
    place:     place_i,
    dur:       dur_i,
    sync_high: sync_high_i,
    src_ext:   src_ext_i,
    ext_low:   ext_low_i
  };

  clamp_cfg_reg #(
    .DEF_PLACE     (DEF_PLACE),
    .DEF_DUR       (DEF_DUR),
    .DEF_SYNC_HIGH (DEF_SYNC_HIGH),
    .DEF_SRC_EXT   (DEF_SRC_EXT),
    .DEF_EXT_LOW   (DEF_EXT_LOW)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load_i),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_q)
  );

  clamp_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (line_sync_i),
    .act_high_i (cfg_q.sync_high),
    .trail_o    (trail)
  );

  clamp_timer u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trail_i (trail),
    .place_i (cfg_q.place),
    .dur_i   (cfg_q.dur),
    .clamp_o (int_clamp)
  );

  clamp_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ext_clamp_i ^ cfg_q.ext_low),
    .q_o    (ext_lvl)
  );

  assign clamp_o = cfg_q.src_ext ? ext_lvl : int_clamp;

  // R9
  ext_isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.src_ext && !ext_lvl && $rose(int_clamp)) |-> !clamp_o);

endmodule

// File: tb/clamp_pulse_gen_test.sv
`timescale 1ns/1ps
module clamp_pulse_gen_test;
  import clamp_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_sync_i = 1'b0;
  logic       ext_clamp_i = 1'b1;
  logic       cfg_load_i = 1'b0;
  logic [7:0] place_i = '0;
  logic [7:0] dur_i = '0;
  logic       sync_high_i = 1'b0;
  logic       src_ext_i = 1'b0;
  logic       ext_low_i = 1'b0;
  logic       clamp_o;

  clamp_pulse_gen uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .line_sync_i (line_sync_i),
    .ext_clamp_i (ext_clamp_i),
    .cfg_load_i  (cfg_load_i),
    .place_i     (place_i),
    .dur_i       (dur_i),
    .sync_high_i (sync_high_i),
    .src_ext_i   (src_ext_i),
    .ext_low_i   (ext_low_i),
    .clamp_o     (clamp_o)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  int    m_place = 128;
  int    m_dur = 128;
  bit    m_high = 1'b1;
  bit    m_ext = 1'b0;
  bit    m_low = 1'b1;
  bit    lvl_prev = 1'b0;
  int    t_last = -100000;
  int    t_prev = -100000;
  bit    ed_cur = 1'b0;
  bit    ed_prev = 1'b0;
  string cur_tag = "";

  function automatic bit exp_clamp(int m);
    int n, k;
    if (m_ext) return ed_prev;
    n = (t_last + 2 <= m) ? t_last : t_prev;
    k = m - n - 2;
    return (m_dur != 0) && (k >= m_place) && (k < m_place + m_dur);
  endfunction

  function automatic string auto_tag();
    if (cur_tag != "") return cur_tag;
    if (m_ext)         return "R8";
    if (m_dur == 0)    return "R5";
    if (m_place == 0)  return "R6";
    return "R4";
  endfunction

  task automatic compare(input bit act, input bit exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      if (n_bad <= 30)
        $display("FAIL %s cyc %0d clamp_o=%0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  task automatic check_now();
    compare(clamp_o, exp_clamp(cyc), auto_tag());
  endtask

  task automatic tick(input bit s, input bit e);
    @(negedge clk);
    check_now();
    if (lvl_prev && !s) begin
      t_prev = t_last;
      t_last = cyc + 1;
    end
    lvl_prev    = s;
    line_sync_i = s ^ ~m_high;
    ed_prev     = ed_cur;
    ed_cur      = e;
    ext_clamp_i = e ^ m_low;
    cfg_load_i  = 1'b0;
  endtask

  task automatic load(input int p, input int d, input bit hi, input bit ex, input bit lo);
    @(negedge clk);
    check_now();
    place_i     = 8'(p);
    dur_i       = 8'(d);
    sync_high_i = hi;
    src_ext_i   = ex;
    ext_low_i   = lo;
    cfg_load_i  = 1'b1;
    m_place = p; m_dur = d; m_high = hi; m_ext = ex; m_low = lo;
    ed_prev = ed_cur;
  endtask

  task automatic line(input int a, input int g);
    repeat (a) tick(1'b1, 1'b0);
    repeat (g) tick(1'b0, 1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) tick(1'b0, 1'b0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog cyc %0d clamp_o=%0b expected run end", cyc, clamp_o);
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R1 reset state
    compare(clamp_o, 1'b0, "R1");
    rst_n = 1'b1;
    cur_tag = "R1";
    line(5, 300);
    // R2 field inputs without load must not matter
    cur_tag = "R2";
    @(negedge clk);
    place_i = 8'd3; dur_i = 8'd4; sync_high_i = 1'b0; src_ext_i = 1'b1;
    line(3, 300);
    cur_tag = "";
    // R4 / R5 / R6 directed corners
    load(5, 7, 1, 0, 1);    line(4, 40);
    load(0, 3, 1, 0, 1);    line(2, 20);
    load(9, 0, 1, 0, 1);    line(3, 40);
    load(0, 1, 1, 0, 1);    line(1, 10);
    load(1, 1, 1, 0, 1);    line(1, 10);
    load(255, 255, 1, 0, 1); line(2, 530);
    // R7 restart during hold and during placement
    cur_tag = "R7";
    load(10, 20, 1, 0, 1);
    line(3, 15); line(3, 15); line(3, 5); line(3, 5); line(3, 60);
    // R3 active-low sync
    cur_tag = "R3";
    load(6, 5, 0, 0, 1);
    idle(5);
    for (int i = 0; i < 8; i++) line($urandom_range(1, 6), $urandom_range(2, 30));
    idle(40);
    load(6, 5, 1, 0, 1);
    idle(5);
    // R10 long active sync gives no pulse until its end
    cur_tag = "R10";
    load(4, 6, 1, 0, 1);
    idle(5);
    repeat (60) tick(1'b1, 1'b0);
    cur_tag = "R4";
    idle(30);
    // R8 external clamp, both polarities
    cur_tag = "R8";
    load(0, 5, 1, 1, 0);
    for (int i = 0; i < 200; i++) tick(1'b0, 1'($urandom_range(0, 1)));
    load(0, 5, 1, 1, 1);
    for (int i = 0; i < 200; i++) tick(1'b0, 1'($urandom_range(0, 1)));
    // R9 sync traffic in external mode with clamp held inactive
    cur_tag = "R9";
    for (int i = 0; i < 10; i++) line($urandom_range(1, 5), $urandom_range(3, 20));
    idle(20);
    cur_tag = "";
    load(0, 5, 1, 0, 1);
    idle(5);
    // random mix
    for (int it = 0; it < 30; it++) begin
      int p, d;
      p = (it % 7 == 0) ? 0 : $urandom_range(0, 40);
      d = (it % 9 == 0) ? 0 : $urandom_range(1, 40);
      if (it % 11 == 5) d = 255;
      load(p, d, 1'($urandom_range(0, 1)), 1'b0, 1'b1);
      idle(2);
      for (int j = 0; j < 6; j++) line($urandom_range(1, 8), $urandom_range(1, 70));
      idle(520);
      if (it % 5 == 4) begin
        load(p, d, m_high, 1'b1, 1'($urandom_range(0, 1)));
        for (int j = 0; j < 100; j++)
          tick(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        idle(520);
      end
    end
    report();
  end

endmodule